// File: doc/BRIEF.md
# Cipher Data Width-Bridging FIFOs

This block sits between a 64-bit host register port and a 128-bit cipher core. It holds one FIFO on each side of the core. On the input side, every host write stores one 64-bit word. The core then takes two words at a time as a 128-bit block. On the output side, the core deposits each 128-bit result as two words, and every host read removes one word. Two ready flags tell the host when it may move data. Each flag compares a byte count of one FIFO against a byte threshold supplied by the unit's mode register.

A message may be of any length. The host marks its final word with a side bit. A separate size register holds the number of valid bits in the final 128-bit block. The bits above that count are forced to zero before the block reaches the core. This also covers a final word that would otherwise sit alone in the lower half of a block. The first write sets a sticky flag that marks the shared FIFOs as claimed by this unit. A write to a full input FIFO or a read from an empty output FIFO raises a sticky error and leaves the FIFO untouched.

Top module: `cfb_fifo_bridge`

## Requirements
- R1: After reset both FIFOs are empty, `access_err` and `fifo_reserved` are 0, `core_in_valid` is 0, `core_out_ready` is 1, and the size register holds 128.
- R2: Words written by the host reach the core in write order. In each 128-bit block, bits [63:0] carry the earlier word and bits [127:64] the later word.
- R3: `core_in_valid` is 1 when the input FIFO holds at least two words, or when its oldest word is marked final. A cycle with both valid and ready removes the words of that block.
- R4: When a block contains a final word, every block bit at an index at or above the size register value is 0. A final word in the lower half is sent alone with zeros above it. A size value of 0 or above 128 counts as 128. A size write takes effect on the next cycle.
- R5: `in_wr_ready` is 1 exactly when 8 × (DEPTH − input word count) is at or above `in_thresh`.
- R6: `out_rd_ready` is 1 exactly when 8 × output word count is at or above `out_thresh`.
- R7: `core_out_ready` is 1 exactly when at least two output entries are free. An accepted result is stored as bits [63:0] first and bits [127:64] second.
- R8: `host_rd_data` shows the oldest output word whenever the output FIFO is not empty. A host read removes that word.
- R9: A host write while the input FIFO holds DEPTH words is dropped, even if the core removes words in the same cycle. It sets `access_err`, which stays set until reset.
- R10: A host read while the output FIFO is empty removes nothing and sets `access_err`. A core result accepted in the same cycle is still stored.
- R11: `fifo_reserved` rises after the first host write, whether or not that write was accepted, and stays set until reset.
- R12: A host write and a core block removal in the same cycle leave the input count changed by the net amount. The same holds for a host read and a core result push on the output FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_wr_en | input | 1 | Host write strobe to the FIFO address |
| host_wr_last | input | 1 | Marks the written word as the final word of the message |
| host_wr_data | input | 64 | Word written by the host |
| host_rd_en | input | 1 | Host read strobe to the FIFO address |
| host_rd_data | output | 64 | Oldest word of the output FIFO |
| in_thresh | input | 9 | Input free-space threshold in bytes, from the mode register |
| out_thresh | input | 9 | Output fill threshold in bytes, from the mode register |
| size_wr_en | input | 1 | Write strobe for the final-block size register |
| size_wr_bits | input | 8 | Number of valid bits in the final block |
| core_in_valid | output | 1 | A 128-bit block is offered to the core |
| core_in_ready | input | 1 | Core accepts the offered block |
| core_in_data | output | 128 | Block offered to the core |
| core_out_valid | input | 1 | Core offers a 128-bit result |
| core_out_ready | output | 1 | Result can be stored |
| core_out_data | input | 128 | Result offered by the core |
| in_wr_ready | output | 1 | Input free space at or above threshold |
| out_rd_ready | output | 1 | Output fill at or above threshold |
| fifo_reserved | output | 1 | Shared FIFOs claimed by this unit |
| access_err | output | 1 | Sticky overflow/underflow error |

## Verification
Two pairs of events can fall in the same cycle. A host write can meet a core block removal on the input FIFO, and a host read can meet a core result push on the output FIFO. The bench forces both pairs on purpose. It writes into a completely full input FIFO while the core is taking a block, and it reads an empty output FIFO while the core is pushing a result. It then judges the outcome through the threshold flags, which are set so that they change state on a single word of difference. A queue-based model compares every output on every clock. A random phase then keeps producing these collisions together with final-word padding.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
  localparam int WORD_W = 64;
  localparam int BLK_W  = 128;
  localparam int SIZE_W = 8;

  typedef struct packed {
    logic              last;
    logic [WORD_W-1:0] data;
  } in_word_t;
endpackage

// File: rtl/cfb_rst_sync.sv
module cfb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_int_n = sync_q[1];
endmodule

// File: rtl/cfb_word_fifo.sv
module cfb_word_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       push_n,
  input  logic [W-1:0]     push_lo,
  input  logic [W-1:0]     push_hi,
  input  logic [1:0]       pop_n,
  output logic [W-1:0]     head_lo,
  output logic [W-1:0]     head_hi,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, wr_ptr_nx, wr_ptr_p1;
  logic [PTR_W-1:0] rd_ptr, rd_ptr_nx, rd_ptr_p1;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    wr_ptr_p1 = wr_ptr + PTR_W'(1);
    rd_ptr_p1 = rd_ptr + PTR_W'(1);
    wr_ptr_nx = wr_ptr + PTR_W'(push_n);
    rd_ptr_nx = rd_ptr + PTR_W'(pop_n);
    cnt_nx    = count + CNT_W'(push_n) - CNT_W'(pop_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      count  <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (push_n != 2'd0) mem[wr_ptr]    <= push_lo;
    if (push_n == 2'd2) mem[wr_ptr_p1] <= push_hi;
  end

  assign head_lo = mem[rd_ptr];
  assign head_hi = mem[rd_ptr_p1];

  AST_NO_OVERPOP: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(pop_n) <= count) else $error("pop beyond fill");                 // R3
  AST_NO_OVERPUSH: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(push_n) <= CNT_W'(DEPTH) - count) else $error("push beyond room"); // R12
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)) else $error("count out of range");             // R12
endmodule

// File: rtl/cfb_block_pack.sv
module cfb_block_pack
  import cfb_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  in_word_t           head0,
  input  in_word_t           head1,
  input  logic [CNT_W-1:0]   count,
  input  logic [SIZE_W-1:0]  size_bits,
  output logic               blk_valid,
  output logic [BLK_W-1:0]   blk_data,
  output logic [1:0]         blk_words
);
  logic [SIZE_W-1:0] eff_bits;
  logic [BLK_W-1:0]  keep_mask;
  logic [BLK_W-1:0]  raw;
  logic              single, has_last;

  always_comb begin
    eff_bits = ((size_bits == '0) || (size_bits > SIZE_W'(BLK_W))) ? SIZE_W'(BLK_W) : size_bits;
  end

  for (genvar i = 0; i < BLK_W; i++) begin : g_mask
    assign keep_mask[i] = (SIZE_W'(i) < eff_bits);
  end

  always_comb begin
    single    = head0.last;
    has_last  = single | head1.last;
    blk_valid = (count >= CNT_W'(2)) || ((count != '0) && single);
    raw       = single ? {{WORD_W{1'b0}}, head0.data} : {head1.data, head0.data};
    blk_data  = has_last ? (raw & keep_mask) : raw;
    blk_words = single ? 2'd1 : 2'd2;
  end
endmodule

// File: rtl/cfb_thresh_flags.sv
module cfb_thresh_flags #(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int THR_W = $clog2(DEPTH * 8 + 1)
) (
  input  logic [CNT_W-1:0] in_cnt,
  input  logic [CNT_W-1:0] out_cnt,
  input  logic [THR_W-1:0] in_thr,
  input  logic [THR_W-1:0] out_thr,
  output logic             in_rdy,
  output logic             out_rdy
);
  logic [THR_W-1:0] in_free_b, out_fill_b;

  always_comb begin
    in_free_b  = (THR_W'(DEPTH) - THR_W'(in_cnt)) << 3;
    out_fill_b = THR_W'(out_cnt) << 3;
    in_rdy     = in_free_b >= in_thr;
    out_rdy    = out_fill_b >= out_thr;
  end
endmodule

// File: rtl/cfb_fifo_bridge.sv
module cfb_fifo_bridge
  import cfb_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int THR_W = $clog2(DEPTH * 8 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic              host_wr_last,
  input  logic [63:0]       host_wr_data,
  input  logic              host_rd_en,
  output logic [63:0]       host_rd_data,
  input  logic [THR_W-1:0]  in_thresh,
  input  logic [THR_W-1:0]  out_thresh,
  input  logic              size_wr_en,
  input  logic [7:0]        size_wr_bits,
  output logic              core_in_valid,
  input  logic              core_in_ready,
  output logic [127:0]      core_in_data,
  input  logic              core_out_valid,
  output logic              core_out_ready,
  input  logic [127:0]      core_out_data,
  output logic              in_wr_ready,
  output logic              out_rd_ready,
  output logic              fifo_reserved,
  output logic              access_err
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IN_W  = $bits(in_word_t);

  logic             rst_int_n;
  logic [CNT_W-1:0] in_cnt, out_cnt;
  in_word_t         in_head0, in_head1, in_word;
  logic [1:0]       in_pop_n, blk_words;
  logic             blk_valid, wr_ok, rd_ok, core_in_fire, core_out_fire;
  logic [63:0]      out_head_hi;
  logic [SIZE_W-1:0] size_q, size_nx;
  logic             err_nx, resv_nx;

  cfb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n));

  always_comb begin
    in_word       = '{last: host_wr_last, data: host_wr_data};
    wr_ok         = host_wr_en && (in_cnt != CNT_W'(DEPTH));
    rd_ok         = host_rd_en && (out_cnt != '0);
    core_in_valid = blk_valid;
    core_in_fire  = blk_valid && core_in_ready;
    in_pop_n      = core_in_fire ? blk_words : 2'd0;
    core_out_ready = out_cnt <= CNT_W'(DEPTH - 2);
    core_out_fire = core_out_valid && core_out_ready;
    err_nx        = access_err | (host_wr_en && !wr_ok) | (host_rd_en && !rd_ok);
    resv_nx       = fifo_reserved | host_wr_en;
    size_nx       = size_wr_en ? size_wr_bits : size_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      access_err    <= 1'b0;
      fifo_reserved <= 1'b0;
      size_q        <= SIZE_W'(BLK_W);
    end else begin
      access_err    <= err_nx;
      fifo_reserved <= resv_nx;
      size_q        <= size_nx;
    end
  end

  cfb_word_fifo #(.W(IN_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_in_fifo (
    .clk(clk), .rst_n(rst_int_n),
    .push_n({1'b0, wr_ok}), .push_lo(in_word), .push_hi('0),
    .pop_n(in_pop_n), .head_lo(in_head0), .head_hi(in_head1), .count(in_cnt)
  );

  cfb_block_pack #(.CNT_W(CNT_W)) u_pack (
    .head0(in_head0), .head1(in_head1), .count(in_cnt), .size_bits(size_q),
    .blk_valid(blk_valid), .blk_data(core_in_data), .blk_words(blk_words)
  );

  cfb_word_fifo #(.W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_out_fifo (
    .clk(clk), .rst_n(rst_int_n),
    .push_n(core_out_fire ? 2'd2 : 2'd0),
    .push_lo(core_out_data[63:0]), .push_hi(core_out_data[127:64]),
    .pop_n({1'b0, rd_ok}), .head_lo(host_rd_data), .head_hi(out_head_hi), .count(out_cnt)
  );

  cfb_thresh_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W)) u_flags (
    .in_cnt(in_cnt), .out_cnt(out_cnt), .in_thr(in_thresh), .out_thr(out_thresh),
    .in_rdy(in_wr_ready), .out_rdy(out_rd_ready)
  );

  AST_FULL_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_int_n)
    host_wr_en && (in_cnt == CNT_W'(DEPTH)) |=> access_err) else $error("full write"); // R9
  AST_FULL_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    host_wr_en && (in_cnt == CNT_W'(DEPTH)) && !core_in_fire |=> $stable(in_cnt)) else $error("full write stored"); // R9
  AST_EMPTY_READ_ERR: assert property (@(posedge clk) disable iff (!rst_int_n)
    host_rd_en && (out_cnt == '0) |=> access_err) else $error("empty read"); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    access_err |=> access_err) else $error("error dropped"); // R9
  AST_RESV_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    fifo_reserved |=> fifo_reserved) else $error("claim dropped"); // R11
  AST_OUT_VOLUME: assert property (@(posedge clk) disable iff (!rst_int_n)
    core_out_fire |=> out_cnt == $past(out_cnt) + CNT_W'(2) - CNT_W'($past(rd_ok))) else $error("result volume"); // R7
  AST_READ_ORDER: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_ok && (out_cnt >= CNT_W'(2)) |=> host_rd_data == $past(out_head_hi)) else $error("read order"); // R8
endmodule

// File: tb/cfb_fifo_bridge_test.sv
module cfb_fifo_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_last, rd_en, sz_en, ci_ready, co_valid;
  logic [63:0] wr_data;
  logic [7:0] sz_bits;
  logic [8:0] in_thr, out_thr;
  logic [127:0] co_data;
  logic [63:0] rd_data;
  logic ci_valid, co_ready, in_rdy, out_rdy, resv, err;
  logic [127:0] ci_data;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [63:0] m_in[$];
  bit          m_last[$];
  logic [63:0] m_out[$];
  bit          m_err, m_resv;
  int          m_size;
  string       m_err_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfb_fifo_bridge #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(wr_en), .host_wr_last(wr_last), .host_wr_data(wr_data),
    .host_rd_en(rd_en), .host_rd_data(rd_data),
    .in_thresh(in_thr), .out_thresh(out_thr),
    .size_wr_en(sz_en), .size_wr_bits(sz_bits),
    .core_in_valid(ci_valid), .core_in_ready(ci_ready), .core_in_data(ci_data),
    .core_out_valid(co_valid), .core_out_ready(co_ready), .core_out_data(co_data),
    .in_wr_ready(in_rdy), .out_rd_ready(out_rdy), .fifo_reserved(resv), .access_err(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  function automatic bit mdl_valid();
    return (m_in.size() >= 2) || (m_in.size() >= 1 && m_last[0]);
  endfunction

  function automatic logic [127:0] mdl_block(output bit had_last);
    logic [127:0] raw, mask;
    int n;
    n = (m_size == 0 || m_size > 128) ? 128 : m_size;
    mask = (n >= 128) ? {128{1'b1}} : ((128'd1 << n) - 128'd1);
    if (m_last[0]) begin
      raw = {64'd0, m_in[0]};
      had_last = 1'b1;
    end else begin
      raw = {m_in[1], m_in[0]};
      had_last = m_last[1];
    end
    return had_last ? (raw & mask) : raw;
  endfunction

  task automatic compare();
    bit hl;
    logic [127:0] eb;
    chk(in_rdy == (((DEPTH - m_in.size()) * 8) >= int'(in_thr)), "R5", 128'(in_rdy), 128'(((DEPTH - m_in.size()) * 8) >= int'(in_thr)));
    chk(out_rdy == ((m_out.size() * 8) >= int'(out_thr)), "R6", 128'(out_rdy), 128'((m_out.size() * 8) >= int'(out_thr)));
    chk(err == m_err, m_err_tag, 128'(err), 128'(m_err));
    chk(resv == m_resv, "R11", 128'(resv), 128'(m_resv));
    chk(ci_valid == mdl_valid(), "R3", 128'(ci_valid), 128'(mdl_valid()));
    chk(co_ready == (m_out.size() <= DEPTH - 2), "R7", 128'(co_ready), 128'(m_out.size() <= DEPTH - 2));
    if (mdl_valid()) begin
      eb = mdl_block(hl);
      chk(ci_data == eb, hl ? "R4" : "R2", ci_data, eb);
    end
    if (m_out.size() > 0) chk(rd_data == m_out[0], "R8", 128'(rd_data), 128'(m_out[0]));
  endtask

  task automatic tick();
    bit fire_in, hl, wr_acc, rd_acc, co_fire;
    logic [127:0] blk;
    fire_in = mdl_valid() && ci_ready;
    wr_acc  = wr_en && (m_in.size() < DEPTH);
    rd_acc  = rd_en && (m_out.size() > 0);
    co_fire = co_valid && (m_out.size() <= DEPTH - 2);
    if (wr_en && !wr_acc) begin m_err = 1'b1; m_err_tag = "R9"; end
    if (rd_en && !rd_acc) begin m_err = 1'b1; m_err_tag = "R10"; end
    if (fire_in) begin
      blk = mdl_block(hl);
      if (m_last[0]) begin void'(m_in.pop_front()); void'(m_last.pop_front()); end
      else begin
        void'(m_in.pop_front()); void'(m_last.pop_front());
        void'(m_in.pop_front()); void'(m_last.pop_front());
      end
    end
    if (wr_acc) begin m_in.push_back(wr_data); m_last.push_back(wr_last); end
    if (rd_acc) void'(m_out.pop_front());
    if (co_fire) begin m_out.push_back(co_data[63:0]); m_out.push_back(co_data[127:64]); end
    if (wr_en) m_resv = 1'b1;
    if (sz_en) m_size = int'(sz_bits);
    @(posedge clk);
    @(negedge clk);
    cyc++;
    compare();
    wr_en = 0; wr_last = 0; rd_en = 0; co_valid = 0; sz_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 0; wr_last = 0; rd_en = 0; co_valid = 0; sz_en = 0; ci_ready = 0;
    wr_data = '0; co_data = '0; sz_bits = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_in.delete(); m_last.delete(); m_out.delete();
    m_err = 0; m_resv = 0; m_size = 128; m_err_tag = "R9";
  endtask

  task automatic host_write(input logic [63:0] d, input bit last);
    wr_en = 1; wr_data = d; wr_last = last;
    tick();
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_thr = 9'd8; out_thr = 9'd8;
    do_reset();
    // R1: reset state
    chk(ci_valid == 0, "R1", 128'(ci_valid), 128'd0);
    chk(co_ready == 1, "R1", 128'(co_ready), 128'd1);
    chk(err == 0 && resv == 0, "R1", 128'({err, resv}), 128'd0);
    chk(in_rdy == 1 && out_rdy == 0, "R1", 128'({in_rdy, out_rdy}), 128'b10);

    // R2/R3: four words, core stalled then released
    for (int i = 0; i < 4; i++) host_write(64'h1111_0000_0000_0000 + 64'(i), i == 3);
    ci_ready = 1; tick(); tick(); tick();
    ci_ready = 0;

    // R4: padding cases
    sz_en = 1; sz_bits = 8'd40; tick();
    host_write(rnd64(), 1); ci_ready = 1; tick(); ci_ready = 0;
    sz_en = 1; sz_bits = 8'd100; tick();
    host_write(rnd64(), 0); host_write(rnd64(), 1); ci_ready = 1; tick(); ci_ready = 0;
    sz_en = 1; sz_bits = 8'd0; tick();
    host_write(rnd64(), 0); host_write(rnd64(), 1); ci_ready = 1; tick(); ci_ready = 0;
    sz_en = 1; sz_bits = 8'd200; tick();
    host_write(rnd64(), 1); ci_ready = 1; tick(); ci_ready = 0;

    // R5/R9/R12: fill input, write at full while core pops
    in_thr = 9'd64;
    for (int i = 0; i < DEPTH; i++) host_write(rnd64(), 0);
    in_thr = 9'd16;
    ci_ready = 1; host_write(64'hDEAD_BEEF_DEAD_BEEF, 0);
    ci_ready = 0;
    chk(in_rdy == 1 && err == 1, "R9", 128'({in_rdy, err}), 128'b11);
    in_thr = 9'd24;
    ci_ready = 1; host_write(rnd64(), 0);
    ci_ready = 0;
    chk(in_rdy == 1, "R12", 128'(in_rdy), 128'd1);
    in_thr = 9'd32; tick();
    chk(in_rdy == 0, "R12", 128'(in_rdy), 128'd0);
    ci_ready = 1;
    repeat (20) tick();
    ci_ready = 0;

    // R10/R7/R8/R6: output side
    do_reset();
    out_thr = 9'd16;
    rd_en = 1; co_valid = 1; co_data = {rnd64(), rnd64()}; tick();
    chk(err == 1 && out_rdy == 1, "R10", 128'({err, out_rdy}), 128'b11);
    for (int i = 0; i < 16; i++) begin co_valid = 1; co_data = {rnd64(), rnd64()}; tick(); end
    chk(co_ready == 0, "R7", 128'(co_ready), 128'd0);
    rd_en = 1; co_valid = 1; co_data = {rnd64(), rnd64()}; tick();
    rd_en = 1; tick();
    rd_en = 1; co_valid = 1; co_data = {rnd64(), rnd64()}; tick();
    out_thr = 9'd248; tick();
    chk(out_rdy == 1, "R12", 128'(out_rdy), 128'd1);
    for (int i = 0; i < 33; i++) begin rd_en = 1; tick(); end

    // random collisions
    for (int r = 0; r < 3; r++) begin
      do_reset();
      for (int i = 0; i < 1500; i++) begin
        in_thr = 9'($urandom_range(0, 260));
        out_thr = 9'($urandom_range(0, 260));
        ci_ready = ($urandom_range(0, 2) != 0);
        wr_en = ($urandom_range(0, 3) != 0); wr_data = rnd64(); wr_last = ($urandom_range(0, 4) == 0);
        rd_en = ($urandom_range(0, 2) == 0);
        co_valid = ($urandom_range(0, 1) == 0); co_data = {rnd64(), rnd64()};
        sz_en = ($urandom_range(0, 15) == 0); sz_bits = 8'($urandom_range(0, 255));
        tick();
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule